// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 36-bit words. Its write side and its read side each have their own clock. The two clocks may be unrelated, or both sides may be driven from one shared clock. The storage is an internal array with a depth of `2**ADDR_W` words. The pointers pass between the two clock domains as Gray codes through a chain of synchronizing flops. Each side therefore sees its own activity at once and sees the other side's activity a fixed number of clocks later.

Two reset inputs act on the block:
- A master reset empties the buffer. It also captures three configuration inputs: the flag timing style, the preset offset choice and the offset loading method.
- A partial reset empties the buffer and leaves every configuration register untouched.

The block supports two flag timing styles:
- **Standard style.** The status outputs act as full and empty. The caller must request every word it reads.
- **Look-ahead style.** The status outputs act as input-ready and output-ready. The oldest word is presented on the output without a request.

Each side has a threshold flag: almost-full on the write side and almost-empty on the read side. Their offsets start from a preset chosen at master reset. After that, they can be reloaded bit by bit through a serial input or word by word through the data bus. A rewind input returns the read side to the first word stored since the last reset, so the stored data can be read out again.

Top module: `dcfifo_pflag`

## Requirements
- R1: In standard style (`cfg_fwft`=0 captured at master reset), `rd_stat` is 1 exactly when the read side sees no stored word. A read with `rd_en`=1 while `rd_stat`=0 places the oldest word on `rdata` after that read-clock edge, and `rdata` holds its value until the next accepted read.
- R2: In look-ahead style (`cfg_fwft`=1), `rd_stat` is 1 while a word is presented on `rdata`.
  - The oldest stored word is loaded into `rdata` without any request.
  - `rd_en`=1 while `rd_stat`=1 consumes the presented word, and the next word, if any, replaces it on the same edge.
- R3: `wr_stat` reports full in standard style (1 = full) and input-ready in look-ahead style (1 = room). Full means that the write-side count equals `2**ADDR_W`. A write while full is dropped, and the stored data and the count are left unchanged.
- R4: A read request in standard style while empty is ignored. `rdata` stays the same and no word is lost.
- R5: `wr_afull` is 1 when the write-side count plus the almost-full offset is at least `2**ADDR_W`.
- R6: `rd_aempty` is 1 when the read-side occupancy is at most the almost-empty offset. In look-ahead style the occupancy includes the word held on `rdata`.
- R7: At master reset both offsets load the preset chosen by `cfg_sel`, which takes these values:

  | `cfg_sel` | Offset (words) |
  |-----------|----------------|
  | 0 | 8 |
  | 1 | 16 |
  | 2 | 64 |
  | 3 | 256 |
  | 4 to 7 | 1024 |

- R8: Parallel loading applies when `cfg_serial`=0 was captured at master reset.
  - A write-clock edge with `ofs_ld`=1 and `wr_en`=1 stores `wdata[OW-1:0]` into an offset, where OW = max(11, ADDR_W+1).
  - The first such edge after any reset loads the almost-empty offset, the next loads the almost-full offset, and then the two alternate.
  - With `ofs_ld`=1, `wr_en` never writes a word into the buffer, in either loading method.
- R9: Serial loading applies when `cfg_serial`=1 was captured.
  - Each write-clock edge with `ofs_sen`=1 shifts `ofs_sdi` into bit 0 of the almost-full offset.
  - The top bit of the almost-full offset moves into bit 0 of the almost-empty offset, so 2·OW bits load both offsets, most significant bit first.
  - In parallel loading, `ofs_sen` has no effect.
- R10: Master reset (`mrst`=1 at a clock edge) empties the buffer, clears `rdata` to 0 and captures `cfg_fwft`, `cfg_sel` and `cfg_serial`.
- R11: Partial reset (`prst`=1) empties the buffer, clears `rdata` to 0 and restarts the parallel load sequence at the almost-empty offset. It keeps the timing style, the loading method and both offset values.
- R12: A read-clock edge with `rewind`=1 returns the read position to the first word written since the last reset and overrides `rd_en`. In look-ahead style the presented word is dropped and refetched, starting from that first word.
- R13: With `SYNC_STAGES`=2, each side sees the other side's pointer as it stood two of its own clock edges earlier. Flags driven by the local pointer change on the same edge.
- R14: A write and a read may both be accepted on the same edge of a shared clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high; captures configuration |
| prst | input | 1 | Partial reset, synchronous, active high; keeps configuration |
| cfg_fwft | input | 1 | Timing style captured at master reset: 1 look-ahead, 0 standard |
| cfg_sel | input | 3 | Preset offset choice captured at master reset |
| cfg_serial | input | 1 | Offset loading method captured at master reset: 1 serial, 0 parallel |
| wr_en | input | 1 | Write request |
| ofs_ld | input | 1 | Steers a write into the offset registers instead of the buffer |
| wdata | input | DATA_W | Write data |
| ofs_sen | input | 1 | Serial offset shift enable |
| ofs_sdi | input | 1 | Serial offset data bit |
| wr_stat | output | 1 | Full (standard style) or input-ready (look-ahead style) |
| wr_afull | output | 1 | Almost-full flag |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Return the read position to the first stored word |
| rdata | output | DATA_W | Read data |
| rd_stat | output | 1 | Empty (standard style) or output-ready (look-ahead style) |
| rd_aempty | output | 1 | Almost-empty flag |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-word buffer, and keeps the defaults `DATA_W`=36 and `SYNC_STAGES`=2. Both clock inputs come from one clock.

- **Small depth.** A 16-word buffer makes the full condition and the dropped writes reachable within a few dozen cycles. It also lets the 8-word preset place both threshold flags in the middle of the range, while every larger preset holds them permanently asserted.
- **Shared clock.** One clock makes the two-edge crossing latency exact. A behavioural queue model can then predict every flag on every cycle, including during simultaneous writes and reads.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

   // Width of the largest preset offset (1024 needs 11 bits).
   localparam int PRESET_W = 11;

   // Preset selection codes captured at master reset.
   typedef enum logic [2:0] {
      PSEL_8    = 3'd0,
      PSEL_16   = 3'd1,
      PSEL_64   = 3'd2,
      PSEL_256  = 3'd3,
      PSEL_1024 = 3'd4
   } psel_e;

   function automatic logic [PRESET_W-1:0] preset_words(input logic [2:0] sel);
      case (sel)
         PSEL_8:   return PRESET_W'(8);
         PSEL_16:  return PRESET_W'(16);
         PSEL_64:  return PRESET_W'(64);
         PSEL_256: return PRESET_W'(256);
         default:  return PRESET_W'(1024);
      endcase
   endfunction

endpackage

// File: rtl/ptr_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer; delivers binary.
module ptr_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], gray_in};
   end

   function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
      logic [W-1:0] b;
      b[W-1] = g[W-1];
      for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   assign bin_out = gray2bin(chain[STAGES-1]);

endmodule

// File: rtl/fifo_ram.sv
// Inferred dual-port storage: synchronous write, asynchronous read.
module fifo_ram #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 8
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_ctl.sv
// Write-side control: pointer, full / almost-full, configuration, offsets.
module fifo_wr_ctl
   import fifo_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 11
) (
   input  logic             wclk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             cfg_fwft,
   input  logic [2:0]       cfg_sel,
   input  logic             cfg_serial,
   input  logic             wr_en,
   input  logic             ofs_ld,
   input  logic [OFF_W-1:0] ld_word,
   input  logic             ofs_sen,
   input  logic             ofs_sdi,
   input  logic [ADDR_W:0]  rbin_s,
   output logic [ADDR_W:0]  wbin,
   output logic [ADDR_W:0]  wgray,
   output logic             ram_we,
   output logic             wr_stat,
   output logic             wr_afull,
   output logic [OFF_W-1:0] ae_off
);

   localparam int PW = ADDR_W + 1;
   localparam int SW = OFF_W + 1;
   localparam logic [PW-1:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

   logic             fwft_q, serial_q, tgl_q;
   logic [OFF_W-1:0] ae_q, af_q;
   logic [PW-1:0]    wbin_q, wgray_q, wbin_nxt, wcnt;
   logic             full;

   assign wcnt     = wbin_q - rbin_s;
   assign full     = (wcnt == FULL_CNT);
   assign ram_we   = wr_en && !ofs_ld && !full;
   assign wbin_nxt = wbin_q + PW'(ram_we);

   always_ff @(posedge wclk) begin
      if (mrst) begin
         fwft_q   <= cfg_fwft;
         serial_q <= cfg_serial;
         ae_q     <= OFF_W'(preset_words(cfg_sel));
         af_q     <= OFF_W'(preset_words(cfg_sel));
         tgl_q    <= 1'b0;
         wbin_q   <= '0;
         wgray_q  <= '0;
      end else if (prst) begin
         tgl_q    <= 1'b0;
         wbin_q   <= '0;
         wgray_q  <= '0;
      end else begin
         wbin_q   <= wbin_nxt;
         wgray_q  <= wbin_nxt ^ (wbin_nxt >> 1);
         if (serial_q) begin
            if (ofs_sen) {ae_q, af_q} <= {ae_q[OFF_W-2:0], af_q, ofs_sdi};
         end else if (ofs_ld && wr_en) begin
            if (tgl_q) af_q <= ld_word;
            else       ae_q <= ld_word;
            tgl_q <= ~tgl_q;
         end
      end
   end

   assign wbin     = wbin_q;
   assign wgray    = wgray_q;
   assign ae_off   = ae_q;
   assign wr_stat  = fwft_q ? !full : full;
   assign wr_afull = (SW'(wcnt) + SW'(af_q)) >= SW'(FULL_CNT);

   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (mrst || prst)
      wcnt <= FULL_CNT); // R3
   AST_FULL_DROPS: assert property (@(posedge wclk) disable iff (mrst || prst)
      (full && wr_en) |=> $stable(wbin_q)); // R3
   AST_AF_COVERS_FULL: assert property (@(posedge wclk) disable iff (mrst || prst)
      full |-> wr_afull); // R5
   AST_LD_NO_STORE: assert property (@(posedge wclk) disable iff (mrst || prst)
      (ofs_ld && wr_en) |=> $stable(wbin_q)); // R8
   AST_GRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (mrst || prst)
      !$past(mrst || prst) |-> $countones(wgray_q ^ $past(wgray_q)) <= 1); // R13

endmodule

// File: rtl/fifo_rd_ctl.sv
// Read-side control: pointer, output register, empty / ready, almost-empty.
module fifo_rd_ctl #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 11
) (
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              cfg_fwft,
   input  logic              rd_en,
   input  logic              rewind,
   input  logic [ADDR_W:0]   wbin_s,
   input  logic [OFF_W-1:0]  ae_off,
   input  logic [DATA_W-1:0] ram_q,
   output logic [ADDR_W:0]   rbin,
   output logic [ADDR_W:0]   rgray,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_stat,
   output logic              rd_aempty
);

   localparam int PW = ADDR_W + 1;
   localparam int SW = OFF_W + 1;

   logic              fwft_q, oval_q;
   logic [PW-1:0]     rbin_q, rgray_q, rbin_nxt, avail;
   logic [DATA_W-1:0] rdata_q;
   logic              mem_empty, pop;

   assign avail     = wbin_s - rbin_q;
   assign mem_empty = (avail == '0);
   assign pop       = fwft_q ? ((!oval_q || rd_en) && !mem_empty && !rewind)
                             : (rd_en && !mem_empty && !rewind);
   assign rbin_nxt  = rewind ? '0 : (rbin_q + PW'(pop));

   always_ff @(posedge rclk) begin
      if (mrst) begin
         fwft_q  <= cfg_fwft;
         rbin_q  <= '0;
         rgray_q <= '0;
         oval_q  <= 1'b0;
         rdata_q <= '0;
      end else if (prst) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         oval_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         rbin_q  <= rbin_nxt;
         rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
         if (rewind)   oval_q <= 1'b0;
         else          oval_q <= pop || (oval_q && !rd_en);
         if (pop)      rdata_q <= ram_q;
      end
   end

   assign rbin      = rbin_q;
   assign rgray     = rgray_q;
   assign rdata     = rdata_q;
   assign rd_stat   = fwft_q ? oval_q : mem_empty;
   assign rd_aempty = (SW'(avail) + SW'(fwft_q && oval_q)) <= SW'(ae_off);

   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (mrst || prst)
      (!fwft_q && mem_empty && !rewind) |=> $stable(rbin_q) && $stable(rdata_q)); // R4
   AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
      (fwft_q && oval_q && !rd_en && !rewind) |=> oval_q && $stable(rdata_q)); // R2
   AST_AE_WHEN_DRY: assert property (@(posedge rclk) disable iff (mrst || prst)
      (mem_empty && !(fwft_q && oval_q)) |-> rd_aempty); // R6
   AST_REWIND_ORIGIN: assert property (@(posedge rclk) disable iff (mrst || prst)
      rewind |=> (rbin_q == '0) && !(fwft_q && oval_q)); // R12

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
   import fifo_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              cfg_fwft,
   input  logic [2:0]        cfg_sel,
   input  logic              cfg_serial,
   input  logic              wr_en,
   input  logic              ofs_ld,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ofs_sen,
   input  logic              ofs_sdi,
   output logic              wr_stat,
   output logic              wr_afull,
   input  logic              rd_en,
   input  logic              rewind,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_stat,
   output logic              rd_aempty
);

   localparam int PW    = ADDR_W + 1;
   localparam int OFF_W = (PW > PRESET_W) ? PW : PRESET_W;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("dcfifo_pflag: ADDR_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcfifo_pflag: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < OFF_W) begin : g_bad_data
      $error("dcfifo_pflag: DATA_W too narrow for parallel offset loading");
   end

   logic [PW-1:0]     wbin, wgray, rbin, rgray, wbin_s, rbin_s;
   logic [OFF_W-1:0]  ae_off;
   logic              ram_we;
   logic [DATA_W-1:0] ram_q;

   fifo_wr_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_wr (
      .wclk(wclk), .mrst(mrst), .prst(prst),
      .cfg_fwft(cfg_fwft), .cfg_sel(cfg_sel), .cfg_serial(cfg_serial),
      .wr_en(wr_en), .ofs_ld(ofs_ld), .ld_word(wdata[OFF_W-1:0]),
      .ofs_sen(ofs_sen), .ofs_sdi(ofs_sdi), .rbin_s(rbin_s),
      .wbin(wbin), .wgray(wgray), .ram_we(ram_we),
      .wr_stat(wr_stat), .wr_afull(wr_afull), .ae_off(ae_off)
   );

   ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst(mrst || prst), .gray_in(rgray), .bin_out(rbin_s)
   );

   ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst(mrst || prst), .gray_in(wgray), .bin_out(wbin_s)
   );

   fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wclk(wclk), .we(ram_we), .waddr(wbin[ADDR_W-1:0]), .wdata(wdata),
      .raddr(rbin[ADDR_W-1:0]), .rdata(ram_q)
   );

   fifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rd (
      .rclk(rclk), .mrst(mrst), .prst(prst), .cfg_fwft(cfg_fwft),
      .rd_en(rd_en), .rewind(rewind), .wbin_s(wbin_s), .ae_off(ae_off),
      .ram_q(ram_q), .rbin(rbin), .rgray(rgray), .rdata(rdata),
      .rd_stat(rd_stat), .rd_aempty(rd_aempty)
   );

endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
module sim_dcfifo_pflag;

   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int OW = (AW + 1 > 11) ? AW + 1 : 11;

   logic        clk = 1'b0;
   logic        mrst = 1'b1, prst = 1'b0;
   logic        cfg_fwft = 1'b0, cfg_serial = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic        wr_en = 1'b0, ofs_ld = 1'b0, ofs_sen = 1'b0, ofs_sdi = 1'b0;
   logic        rd_en = 1'b0, rewind = 1'b0;
   logic [35:0] wdata = '0;
   logic        wr_stat, wr_afull, rd_stat, rd_aempty;
   logic [35:0] rdata;

   int checks = 0, errors = 0;
   bit started = 0, done = 0;
   string ph = "R10";
   logic [35:0] dval = 36'h100;
   logic [15:0] lf = 16'hACE1;

   always #5 clk = ~clk;

   dcfifo_pflag #(.DATA_W(36), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst),
      .cfg_fwft(cfg_fwft), .cfg_sel(cfg_sel), .cfg_serial(cfg_serial),
      .wr_en(wr_en), .ofs_ld(ofs_ld), .wdata(wdata),
      .ofs_sen(ofs_sen), .ofs_sdi(ofs_sdi),
      .wr_stat(wr_stat), .wr_afull(wr_afull),
      .rd_en(rd_en), .rewind(rewind), .rdata(rdata),
      .rd_stat(rd_stat), .rd_aempty(rd_aempty)
   );

   // ---------------- behavioural reference model ----------------
   int wp, rp, ws1, ws2, rs1, rs2, aeo, afo;
   bit fw, sr, ov, tg;
   logic [35:0] od;
   logic [35:0] hist [D];

   function automatic int preset_of(input logic [2:0] s);
      if (s == 3'd0) return 8;
      if (s == 3'd1) return 16;
      if (s == 3'd2) return 64;
      if (s == 3'd3) return 256;
      return 1024;
   endfunction

   always @(posedge clk) begin
      int  owp, orp, comb;
      bit  full_n, empty_n, wacc, fetch;
      if (mrst || prst) begin
         if (mrst) begin
            fw = cfg_fwft; sr = cfg_serial;
            aeo = preset_of(cfg_sel); afo = aeo;
         end
         tg = 0; wp = 0; rp = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
         ov = 0; od = '0;
      end else begin
         owp = wp; orp = rp;
         full_n  = (wp - rs2) == D;
         empty_n = (ws2 - rp) == 0;
         wacc    = wr_en && !ofs_ld && !full_n;
         // read side
         if (rewind) begin
            rp = 0; ov = 0;
         end else if (!fw) begin
            if (rd_en && !empty_n) begin od = hist[rp % D]; rp++; end
         end else begin
            fetch = (!ov || rd_en) && !empty_n;
            if (fetch) begin od = hist[rp % D]; rp++; ov = 1; end
            else if (rd_en && ov) ov = 0;
         end
         // write side
         if (wacc) begin hist[wp % D] = wdata; wp++; end
         if (sr) begin
            if (ofs_sen) begin
               comb = (aeo << OW) | afo;
               comb = ((comb << 1) | int'(ofs_sdi)) & ((1 << (2 * OW)) - 1);
               aeo = comb >> OW;
               afo = comb & ((1 << OW) - 1);
            end
         end else if (ofs_ld && wr_en) begin
            if (tg) afo = int'(wdata[OW-1:0]);
            else    aeo = int'(wdata[OW-1:0]);
            tg = !tg;
         end
         // pointer crossing, two stages each way
         rs2 = rs1; rs1 = orp;
         ws2 = ws1; ws1 = owp;
      end
   end

   task automatic chk(input string nm, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (phase %s): got %0h expected %0h", nm, ph, act, exp);
      end
   endtask

   task automatic check_all;
      int wc, occ;
      bit full_e;
      wc = wp - rs2;
      full_e = (wc == D);
      occ = (ws2 - rp) + ((fw && ov) ? 1 : 0);
      chk("R3 wr_stat",   36'(wr_stat),   36'(fw ? !full_e : full_e));
      chk("R5 wr_afull",  36'(wr_afull),  36'((wc + afo) >= D));
      chk("R1 R2 rd_stat", 36'(rd_stat),  36'(fw ? ov : ((ws2 - rp) == 0)));
      chk("R6 rd_aempty", 36'(rd_aempty), 36'(occ <= aeo));
      chk("R1 R2 R4 rdata", rdata, od);
   endtask

   task automatic cyc;
      @(posedge clk);
      @(negedge clk);
      if (started && !done) check_all();
      started = 1;
   endtask

   task automatic idle_in;
      wr_en = 0; rd_en = 0; ofs_ld = 0; ofs_sen = 0; rewind = 0; mrst = 0; prst = 0;
   endtask

   task automatic do_mrst(input bit f, input logic [2:0] s, input bit se);
      idle_in(); cfg_fwft = f; cfg_sel = s; cfg_serial = se; mrst = 1;
      cyc(); mrst = 0; cyc();
   endtask

   task automatic wr_n(input int n);
      for (int i = 0; i < n; i++) begin
         idle_in(); wr_en = 1; wdata = dval; dval++; cyc();
      end
      idle_in();
   endtask

   task automatic rd_n(input int n);
      for (int i = 0; i < n; i++) begin idle_in(); rd_en = 1; cyc(); end
      idle_in();
   endtask

   task automatic both_n(input int n);
      for (int i = 0; i < n; i++) begin
         idle_in(); wr_en = 1; rd_en = 1; wdata = dval; dval++; cyc();
      end
      idle_in();
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) begin idle_in(); cyc(); end
   endtask

   task automatic rand_n(input int n);
      for (int i = 0; i < n; i++) begin
         idle_in();
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         wr_en = lf[0] | lf[3];
         rd_en = lf[5] & (lf[1] | lf[7]);
         wdata = {lf, lf, lf[3:0]};
         cyc();
      end
      idle_in();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1; errors++; checks++;
         $display("FAIL watchdog expired in phase %s", ph);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10 R7: master reset, standard style, preset 8, parallel loading
      ph = "R10"; do_mrst(0, 3'd0, 0); idle_n(3);
      // R3 R1 R4: fill past full, then drain past empty
      ph = "R3"; wr_n(20); idle_n(3);
      ph = "R4"; rd_n(20); idle_n(3);
      // R14 R13: writes and reads on the same edges, flag latency
      ph = "R14"; both_n(30); idle_n(4);
      ph = "R13"; wr_n(1); idle_n(3); rd_n(1); idle_n(3);
      // R8: parallel load, almost-empty=3 then almost-full=2
      ph = "R8";
      idle_in(); wr_en = 1; ofs_ld = 1; wdata = 36'd3; cyc();
      idle_in(); wr_en = 1; ofs_ld = 1; wdata = 36'd2; cyc();
      idle_n(3); wr_n(16); idle_n(3); rd_n(16); idle_n(3);
      // R11: partial reset keeps offsets and style
      ph = "R11"; wr_n(4);
      idle_in(); prst = 1; cyc(); idle_n(2);
      wr_n(10); idle_n(3); rd_n(11); idle_n(3);
      // R12: rewind in standard style
      ph = "R12"; idle_in(); prst = 1; cyc(); idle_n(1);
      wr_n(6); idle_n(3); rd_n(3);
      idle_in(); rewind = 1; rd_en = 1; cyc(); idle_n(3); rd_n(8); idle_n(2);
      ph = "R1"; idle_in(); prst = 1; cyc(); rand_n(400); idle_n(4);
      // R7 R2: look-ahead style, preset 16, serial loading
      ph = "R2"; do_mrst(1, 3'd1, 1); wr_n(5); idle_n(4); rd_n(2); idle_n(3); rd_n(4); idle_n(3);
      // R9: serial load of almost-empty=5, almost-full=4; parallel load ignored
      ph = "R9";
      for (int i = 2 * OW - 1; i >= 0; i--) begin
         logic [2*OW-1:0] word;
         word = {OW'(5), OW'(4)};
         idle_in(); ofs_sen = 1; ofs_sdi = word[i]; cyc();
      end
      idle_in(); wr_en = 1; ofs_ld = 1; wdata = 36'd9; cyc(); cyc(); idle_n(3);
      wr_n(18); idle_n(3); rd_n(20); idle_n(3);
      // R12 in look-ahead style
      ph = "R12"; idle_in(); prst = 1; cyc(); idle_n(1);
      wr_n(6); idle_n(4); rd_n(2);
      idle_in(); rewind = 1; cyc(); idle_n(3); rd_n(8); idle_n(2);
      ph = "R14"; idle_in(); prst = 1; cyc(); rand_n(400); idle_n(4);
      // R7: selection codes above 4 pick 1024
      ph = "R7"; do_mrst(0, 3'd5, 0); wr_n(3); idle_n(3); rd_n(3); idle_n(3);
      ph = "R7"; do_mrst(0, 3'd2, 0); wr_n(16); idle_n(3);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule